// File: doc/BRIEF.md
# Data-Link Repeated Codeword Detector

This block listens to the slow serial maintenance channel carried in the framing overhead of a 1.544 Mbit/s line. On that channel a far end announces alarms and commands by sending one 16-bit word over and over. Each word is eight ones followed by an eight-bit code. The block does four things with the bit stream:
- It finds word boundaries at any bit offset.
- It collects the code octet.
- It accepts a code only once it has repeated enough times inside a sliding window of recent words.
- It sorts the accepted code into a category with a detail value.

Recognised commands are held in a message latch. Commands are loopback operate or release with a type, a protection-switch line, acknowledge or release, and a timing-quality level. A held message stays until the channel has carried a run of words that do not match it. Two urgent codes bypass the latch: the remote-alarm code and the loopback-hold code. Each drives its own level output, so either can be reported while an ordinary command is held. An accepted code that belongs to no known category gives a single strobe and leaves the latch untouched.

The design has three parts:
- **Aligner.** A two-state machine. A_HUNT counts ones. The HUNT→CODE transition fires on a zero that follows at least eight ones. A_CODE gathers the remaining seven code bits. The CODE→HUNT transition emits the word.
- **History.** A window of recent codes with a match counter.
- **Tracker.** A two-state machine:
  - T_IDLE→T_HELD (LATCH): a recognised command qualifies.
  - T_HELD→T_HELD (REPLACE): a different recognised command qualifies.
  - T_HELD→T_IDLE (CLEAR): too many consecutive words miss the held code.

Top module: `bom_detector`

## Requirements
- R1: After reset every output is zero: no message active, code, category and detail zero, both urgent levels low, no strobes.
- R2: A word boundary is taken at any offset where a zero follows eight or more ones. That zero is the code's most significant bit, and the next seven accepted bits follow MSB first. A bit is accepted only in a cycle with `dl_valid` high; bits in other cycles are ignored.
- R3: A code qualifies on a word when that word and at least six of the nine words before it carry the same code (7 of the last 10). When a recognised command qualifies and differs from the held one, it is latched and `msg_new` pulses for one cycle. Six repetitions are never enough.
- R4: A held message is dropped after 10 consecutive words whose code differs from it. `msg_active` then falls and code, category and detail return to zero. Any word equal to the held code restarts that count.
- R5: Loopback codes and their category/detail values:
  - Category 1 (operate): 0x70 → 1, 0x04 → 2, 0x68 → 3, 0x28 → 4, 0x48 → 5.
  - Category 2 (release): 0x1C → 1, 0x4C → 4, 0x24 → 7.
- R6: Protection codes:
  - Line n, for n from 1 to 27, uses code {0, n[0], n[1], n[2], n[3], n[4], 1, 0}. It gives category 3 with detail n. This wins over any other meaning of the same octet.
  - 0x18 gives category 4 (acknowledge).
  - 0x64 gives category 5 (release).
- R7: Timing-quality codes give category 6 with these details: 0x30 → 1, 0x38 → 2, 0x3E → 3, 0x0C → 4, 0x14 → 5, 0x44 → 6, 0x02 → 7.
- R8: Code 0x00 sets `alarm_active` and code 0x54 sets `retain_active` when it qualifies. Neither changes the message latch. Each level drops after 10 consecutive words without its code.
- R9: An unrecognised code pulses `unknown_stb` once, on the word where its match count first reaches 7. It neither latches nor replaces the held message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dl_bit | input | 1 | Data-link bit |
| dl_valid | input | 1 | Qualifies `dl_bit` for this cycle |
| msg_code | output | 8 | Held code octet |
| msg_cat | output | 4 | Held category (1 to 6, 0 when idle) |
| msg_detail | output | 5 | Held detail (type, line or level) |
| msg_active | output | 1 | A message is held |
| msg_new | output | 1 | One-cycle pulse when a message is latched |
| alarm_active | output | 1 | Remote-alarm code in force |
| retain_active | output | 1 | Loopback-hold code in force |
| unknown_stb | output | 1 | One-cycle pulse for a qualified unrecognised code |

## Verification
The bench builds the detector with its default parameters: eight prefix ones, an eight-bit code, a 10-word window, acceptance at 7 and clearing at 10.

With these values every code octet whose top bit is zero can be swept. For each one, the bench checks that six repetitions leave all outputs quiet and that the seventh gives the category, urgent level or unknown strobe worked out from the requirement tables. Directed runs then cover:
- alignment at an odd offset with idle cycles between bits;
- dropping the latch after exactly ten mismatching words;
- an urgent level coming and going while a command stays held;
- an unknown code arriving while a command is held.

// File: rtl/bom_pkg.sv
package bom_pkg;

    typedef enum logic [3:0] {
        CAT_NONE      = 4'd0,
        CAT_LOOP_OP   = 4'd1,
        CAT_LOOP_REL  = 4'd2,
        CAT_PROT_LINE = 4'd3,
        CAT_PROT_ACK  = 4'd4,
        CAT_PROT_REL  = 4'd5,
        CAT_SYNC      = 4'd6,
        CAT_ALARM     = 4'd7,
        CAT_RETAIN    = 4'd8,
        CAT_UNKNOWN   = 4'd9
    } msg_cat_e;

    typedef struct packed {
        msg_cat_e    cat;
        logic [4:0]  detail;
    } decode_t;

    localparam logic [7:0] CODE_ALARM  = 8'h00;
    localparam logic [7:0] CODE_RETAIN = 8'h54;
    localparam int         PROT_LINES  = 27;

    function automatic logic is_command(msg_cat_e c);
        return (c != CAT_NONE) && (c != CAT_ALARM) &&
               (c != CAT_RETAIN) && (c != CAT_UNKNOWN);
    endfunction

    function automatic decode_t decode_code(logic [7:0] c);
        decode_t    d;
        logic [4:0] line;
        line     = {c[2], c[3], c[4], c[5], c[6]};
        d.cat    = CAT_UNKNOWN;
        d.detail = 5'd0;
        if (c == CODE_ALARM) begin
            d.cat = CAT_ALARM;
        end else if (c == CODE_RETAIN) begin
            d.cat = CAT_RETAIN;
        end else if (!c[7] && c[1:0] == 2'b10 && line >= 5'd1 &&
                     line <= 5'(PROT_LINES)) begin
            d.cat    = CAT_PROT_LINE;
            d.detail = line;
        end else begin
            case (c)
                8'h70: begin d.cat = CAT_LOOP_OP;  d.detail = 5'd1; end
                8'h04: begin d.cat = CAT_LOOP_OP;  d.detail = 5'd2; end
                8'h68: begin d.cat = CAT_LOOP_OP;  d.detail = 5'd3; end
                8'h28: begin d.cat = CAT_LOOP_OP;  d.detail = 5'd4; end
                8'h48: begin d.cat = CAT_LOOP_OP;  d.detail = 5'd5; end
                8'h1C: begin d.cat = CAT_LOOP_REL; d.detail = 5'd1; end
                8'h4C: begin d.cat = CAT_LOOP_REL; d.detail = 5'd4; end
                8'h24: begin d.cat = CAT_LOOP_REL; d.detail = 5'd7; end
                8'h18: begin d.cat = CAT_PROT_ACK; d.detail = 5'd0; end
                8'h64: begin d.cat = CAT_PROT_REL; d.detail = 5'd0; end
                8'h30: begin d.cat = CAT_SYNC;     d.detail = 5'd1; end
                8'h38: begin d.cat = CAT_SYNC;     d.detail = 5'd2; end
                8'h3E: begin d.cat = CAT_SYNC;     d.detail = 5'd3; end
                8'h0C: begin d.cat = CAT_SYNC;     d.detail = 5'd4; end
                8'h14: begin d.cat = CAT_SYNC;     d.detail = 5'd5; end
                8'h44: begin d.cat = CAT_SYNC;     d.detail = 5'd6; end
                8'h02: begin d.cat = CAT_SYNC;     d.detail = 5'd7; end
                default: ;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/bom_aligner.sv
module bom_aligner #(
    parameter int PREFIX_ONES = 8,
    parameter int CODE_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_in,
    input  logic                 bit_valid,
    output logic                 word_stb,
    output logic [CODE_BITS-1:0] word_code
);
    localparam int OCW = $clog2(PREFIX_ONES + 1);
    localparam int BCW = $clog2(CODE_BITS);

    typedef enum logic {A_HUNT, A_CODE} align_state_e;

    align_state_e         a_state, a_next;
    logic [OCW-1:0]       ones_cnt;
    logic [BCW-1:0]       bit_cnt;
    logic [CODE_BITS-1:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) a_state <= A_HUNT;
        else        a_state <= a_next;
    end

    always_comb begin
        a_next = a_state;
        unique case (a_state)
            A_HUNT: if (bit_valid && !bit_in && ones_cnt == OCW'(PREFIX_ONES))
                        a_next = A_CODE;
            A_CODE: if (bit_valid && bit_cnt == BCW'(CODE_BITS - 1))
                        a_next = A_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_cnt  <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            word_stb  <= 1'b0;
            word_code <= '0;
        end else begin
            word_stb <= 1'b0;
            if (bit_valid) begin
                unique case (a_state)
                    A_HUNT: begin
                        if (bit_in) begin
                            if (ones_cnt != OCW'(PREFIX_ONES))
                                ones_cnt <= ones_cnt + 1'b1;
                        end else begin
                            ones_cnt <= '0;
                            if (ones_cnt == OCW'(PREFIX_ONES)) begin
                                shreg   <= '0;
                                bit_cnt <= BCW'(1);
                            end
                        end
                    end
                    A_CODE: begin
                        shreg   <= {shreg[CODE_BITS-2:0], bit_in};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BCW'(CODE_BITS - 1)) begin
                            word_stb  <= 1'b1;
                            word_code <= {shreg[CODE_BITS-2:0], bit_in};
                            ones_cnt  <= '0;
                        end
                    end
                endcase
            end
        end
    end

    // R2
    stb_from_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> $past(bit_valid));
    // R2
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);
    // R2
    code_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> !word_code[CODE_BITS-1]);

endmodule

// File: rtl/bom_history.sv
module bom_history #(
    parameter int DEPTH = 10,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       word_stb,
    input  logic [WIDTH-1:0]           word_code,
    output logic [$clog2(DEPTH+1)-1:0] match_cnt
);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int OLDS = DEPTH - 1;

    logic [WIDTH-1:0] hist_q [OLDS];
    logic [OLDS-1:0]  hv_q;
    logic [OLDS-1:0]  hit;

    generate
        for (genvar i = 0; i < OLDS; i++) begin : g_slot
            assign hit[i] = hv_q[i] && (hist_q[i] == word_code);
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        hist_q[0] <= '0;
                        hv_q[0]   <= 1'b0;
                    end else if (word_stb) begin
                        hist_q[0] <= word_code;
                        hv_q[0]   <= 1'b1;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        hist_q[i] <= '0;
                        hv_q[i]   <= 1'b0;
                    end else if (word_stb) begin
                        hist_q[i] <= hist_q[i-1];
                        hv_q[i]   <= hv_q[i-1];
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        match_cnt = CW'(1);
        for (int k = 0; k < OLDS; k++)
            match_cnt = match_cnt + CW'(hit[k]);
    end

    // R3
    match_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_cnt >= CW'(1) && match_cnt <= CW'(DEPTH));

endmodule

// File: rtl/bom_tracker.sv
module bom_tracker
    import bom_pkg::*;
#(
    parameter int DEPTH  = 10,
    parameter int ACCEPT = 7,
    parameter int CLEAR  = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       word_stb,
    input  logic [7:0]                 word_code,
    input  logic [$clog2(DEPTH+1)-1:0] match_cnt,
    output logic [7:0]                 msg_code,
    output logic [3:0]                 msg_cat,
    output logic [4:0]                 msg_detail,
    output logic                       msg_active,
    output logic                       msg_new,
    output logic [1:0]                 prio_on,
    output logic                       unknown_stb
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int MW = $clog2(CLEAR + 1);

    typedef enum logic {T_IDLE, T_HELD} track_state_e;

    track_state_e t_state, t_next;
    decode_t      dec;
    logic         qual, is_cmd, same, fresh, expire;
    logic [MW-1:0] miss;

    assign dec    = decode_code(word_code);
    assign qual   = word_stb && (match_cnt >= CW'(ACCEPT));
    assign is_cmd = is_command(dec.cat);
    assign same   = (t_state == T_HELD) && (word_code == msg_code);
    assign fresh  = qual && is_cmd && !same;
    assign expire = word_stb && (t_state == T_HELD) && !same &&
                    (miss == MW'(CLEAR - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) t_state <= T_IDLE;
        else        t_state <= t_next;
    end

    always_comb begin
        t_next = t_state;
        unique case (t_state)
            T_IDLE: if (fresh)       t_next = T_HELD;
            T_HELD: if (fresh)       t_next = T_HELD;
                    else if (expire) t_next = T_IDLE;
        endcase
    end

    assign msg_active = (t_state == T_HELD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_code    <= '0;
            msg_cat     <= '0;
            msg_detail  <= '0;
            miss        <= '0;
            msg_new     <= 1'b0;
            unknown_stb <= 1'b0;
        end else begin
            msg_new     <= 1'b0;
            unknown_stb <= qual && (dec.cat == CAT_UNKNOWN) &&
                           (match_cnt == CW'(ACCEPT));
            if (fresh) begin
                msg_code   <= word_code;
                msg_cat    <= dec.cat;
                msg_detail <= dec.detail;
                miss       <= '0;
                msg_new    <= 1'b1;
            end else if (word_stb && t_state == T_HELD) begin
                if (same) begin
                    miss <= '0;
                end else if (expire) begin
                    miss       <= '0;
                    msg_code   <= '0;
                    msg_cat    <= '0;
                    msg_detail <= '0;
                end else begin
                    miss <= miss + 1'b1;
                end
            end
        end
    end

    generate
        for (genvar p = 0; p < 2; p++) begin : g_prio
            localparam logic [7:0] PC = (p == 0) ? CODE_ALARM : CODE_RETAIN;
            logic [MW-1:0] pmiss;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prio_on[p] <= 1'b0;
                    pmiss      <= '0;
                end else if (word_stb) begin
                    if (word_code == PC) begin
                        pmiss <= '0;
                        if (qual) prio_on[p] <= 1'b1;
                    end else if (prio_on[p]) begin
                        if (pmiss == MW'(CLEAR - 1)) begin
                            prio_on[p] <= 1'b0;
                            pmiss      <= '0;
                        end else begin
                            pmiss <= pmiss + 1'b1;
                        end
                    end
                end
            end
            // R8
            prio_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(prio_on[p]) |-> $past(word_stb));
        end
    endgenerate

    // R3
    new_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_new |-> msg_active);
    // R3
    new_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_new |-> $past(word_stb));
    // R4
    idle_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_active |-> (msg_code == 8'd0 && msg_cat == 4'd0));
    // R9
    unk_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unknown_stb |-> !msg_new);
    // R4
    miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss < MW'(CLEAR));

endmodule

// File: rtl/bom_detector.sv
module bom_detector #(
    parameter int PREFIX_ONES = 8,
    parameter int DEPTH       = 10,
    parameter int ACCEPT      = 7,
    parameter int CLEAR       = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dl_bit,
    input  logic       dl_valid,
    output logic [7:0] msg_code,
    output logic [3:0] msg_cat,
    output logic [4:0] msg_detail,
    output logic       msg_active,
    output logic       msg_new,
    output logic       alarm_active,
    output logic       retain_active,
    output logic       unknown_stb
);
    localparam int CODE_BITS = 8;
    localparam int CW        = $clog2(DEPTH + 1);

    logic                 word_stb;
    logic [CODE_BITS-1:0] word_code;
    logic [CW-1:0]        match_cnt;
    logic [1:0]           prio_on;

    bom_aligner #(.PREFIX_ONES(PREFIX_ONES), .CODE_BITS(CODE_BITS)) u_align (
        .clk(clk), .rst_n(rst_n), .bit_in(dl_bit), .bit_valid(dl_valid),
        .word_stb(word_stb), .word_code(word_code));

    bom_history #(.DEPTH(DEPTH), .WIDTH(CODE_BITS)) u_hist (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .word_code(word_code),
        .match_cnt(match_cnt));

    bom_tracker #(.DEPTH(DEPTH), .ACCEPT(ACCEPT), .CLEAR(CLEAR)) u_track (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .word_code(word_code),
        .match_cnt(match_cnt), .msg_code(msg_code), .msg_cat(msg_cat),
        .msg_detail(msg_detail), .msg_active(msg_active), .msg_new(msg_new),
        .prio_on(prio_on), .unknown_stb(unknown_stb));

    assign alarm_active  = prio_on[0];
    assign retain_active = prio_on[1];

endmodule

// File: tb/bom_detector_test.sv
module bom_detector_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dl_bit = 1'b0;
    logic       dl_valid = 1'b0;
    logic [7:0] msg_code;
    logic [3:0] msg_cat;
    logic [4:0] msg_detail;
    logic       msg_active, msg_new, alarm_active, retain_active, unknown_stb;

    int checks = 0;
    int fails  = 0;
    int new_cnt = 0;
    int unk_cnt = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    bom_detector uut (
        .clk(clk), .rst_n(rst_n), .dl_bit(dl_bit), .dl_valid(dl_valid),
        .msg_code(msg_code), .msg_cat(msg_cat), .msg_detail(msg_detail),
        .msg_active(msg_active), .msg_new(msg_new), .alarm_active(alarm_active),
        .retain_active(retain_active), .unknown_stb(unknown_stb));

    always @(negedge clk) begin
        if (msg_new)     new_cnt++;
        if (unknown_stb) unk_cnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        dl_valid = 1'b0;
        rst_n    = 1'b0;
        repeat (2) @(negedge clk);
        rst_n   = 1'b1;
        new_cnt = 0;
        unk_cnt = 0;
    endtask

    task automatic send_bit(input logic b, input bit gap);
        dl_bit   = b;
        dl_valid = 1'b1;
        @(negedge clk);
        dl_valid = 1'b0;
        if (gap) begin
            dl_bit = ~b;
            @(negedge clk);
        end
    endtask

    task automatic send_word(input logic [7:0] c, input bit gap);
        for (int i = 0; i < 8; i++) send_bit(1'b1, gap);
        for (int i = 7; i >= 0; i--) send_bit(c[i], gap);
    endtask

    task automatic send_reps(input logic [7:0] c, input int n);
        for (int i = 0; i < n; i++) send_word(c, 1'b0);
        repeat (2) @(negedge clk);
    endtask

    // expected category/detail, built from the requirement tables
    function automatic void expect_of(input logic [7:0] c,
                                      output int cat, output int det);
        logic [7:0] lc;
        cat = 9; det = 0;
        if (c == 8'h00) begin cat = 7; return; end
        if (c == 8'h54) begin cat = 8; return; end
        for (int n = 1; n <= 27; n++) begin
            lc = {1'b0, n[0], n[1], n[2], n[3], n[4], 2'b10};
            if (lc == c) begin cat = 3; det = n; return; end
        end
        case (c)
            8'h70: begin cat = 1; det = 1; end
            8'h04: begin cat = 1; det = 2; end
            8'h68: begin cat = 1; det = 3; end
            8'h28: begin cat = 1; det = 4; end
            8'h48: begin cat = 1; det = 5; end
            8'h1C: begin cat = 2; det = 1; end
            8'h4C: begin cat = 2; det = 4; end
            8'h24: begin cat = 2; det = 7; end
            8'h18: begin cat = 4; det = 0; end
            8'h64: begin cat = 5; det = 0; end
            8'h30: begin cat = 6; det = 1; end
            8'h38: begin cat = 6; det = 2; end
            8'h3E: begin cat = 6; det = 3; end
            8'h0C: begin cat = 6; det = 4; end
            8'h14: begin cat = 6; det = 5; end
            8'h44: begin cat = 6; det = 6; end
            8'h02: begin cat = 6; det = 7; end
            default: ;
        endcase
    endfunction

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int ec, ed;
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1", {msg_active, msg_new, alarm_active, retain_active, unknown_stb}, 0);
        check("R1", {msg_code, msg_cat, msg_detail}, 0);

        // sweep all alignable code octets: R3 R5 R6 R7 R8 R9
        for (int v = 0; v < 128; v++) begin
            logic [7:0] c;
            c = 8'(v);
            expect_of(c, ec, ed);
            do_reset();
            send_reps(c, 6);
            check("R3 six reps quiet",
                  {msg_active, alarm_active, retain_active} + unk_cnt, 0);
            send_reps(c, 1);
            if (ec == 7) begin
                check("R8 alarm", {alarm_active, retain_active, msg_active}, 3'b100);
            end else if (ec == 8) begin
                check("R8 retain", {alarm_active, retain_active, msg_active}, 3'b010);
            end else if (ec == 9) begin
                check("R9 unknown strobe", unk_cnt, 1);
                check("R9 no latch", msg_active, 0);
            end else begin
                check("R3 latched", msg_active, 1);
                check("R3 new pulse", new_cnt, 1);
                check("R3 code", msg_code, c);
                check(ec == 3 ? "R6 cat" : (ec == 6 ? "R7 cat" : "R5 cat"), msg_cat, ec);
                check(ec == 3 ? "R6 detail" : (ec == 6 ? "R7 detail" : "R5 detail"),
                      msg_detail, ed);
            end
        end

        // R2 odd offset, idle cycles between bits
        do_reset();
        send_bit(1'b0, 1'b1); send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b1);
        for (int i = 0; i < 7; i++) send_word(8'h28, 1'b1);
        repeat (2) @(negedge clk);
        check("R2 offset+gaps active", msg_active, 1);
        check("R2 offset+gaps code", msg_code, 8'h28);

        // R4 clear after ten mismatches
        do_reset();
        send_reps(8'h28, 7);
        for (int i = 0; i < 9; i++) send_word((i % 2) ? 8'h48 : 8'h04, 1'b0);
        repeat (2) @(negedge clk);
        check("R4 held after 9", msg_active, 1);
        check("R4 code after 9", msg_code, 8'h28);
        send_reps(8'h48, 1);
        check("R4 cleared after 10", msg_active, 0);
        check("R4 blank", {msg_code, msg_cat, msg_detail}, 0);

        // R8 alarm while held, then drop
        do_reset();
        send_reps(8'h28, 7);
        send_reps(8'h00, 7);
        check("R8 alarm while held", alarm_active, 1);
        check("R8 latch kept", msg_code, 8'h28);
        send_reps(8'h28, 9);
        check("R8 alarm after 9 misses", alarm_active, 1);
        send_reps(8'h28, 1);
        check("R8 alarm dropped", alarm_active, 0);
        check("R8 latch still", msg_active, 1);

        // R9 unknown while held
        do_reset();
        send_reps(8'h70, 7);
        send_reps(8'h7F, 7);
        check("R9 strobe once", unk_cnt, 1);
        check("R9 latch kept", msg_code, 8'h70);
        check("R9 no extra new", new_cnt, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule